// File: doc/BRIEF.md
# Paired Vector Register Store Address Unit

This block takes one 32-bit store-pair instruction word for the vector/floating-point register file and turns it into a ready-to-issue memory write. It decodes the register indices, the addressing class and the element size. It picks the base register, which is either a general register value or the stack pointer. From the base it forms the access address and the value to write back to that base. It also joins two register-file read values into one double-width store data word in the order that the current endianness requires.

A pipeline stage gives the unit an instruction word, the general-register base value, the stack pointer, the two vector register read values, an endianness flag and a flag saying whether floating-point support is present, and asserts `in_valid`. Exactly one cycle later the unit presents the registered results with `out_valid` set. The results are the access address, the byte count, the store data, the store and writeback enables, and three flags: undefined instruction, stack-pointer misalignment and tag checking. The register file, the memory system and exception handling sit outside the block.

Top module: `pair_store_agu`

## Requirements
- R1: Results appear on the outputs one clock after a cycle with `in_valid` high, and `out_valid` is high in exactly those cycles. After reset, `out_valid` is 0 and every result output is 0.
- R2: `rt_idx` = insn[4:0], `rt2_idx` = insn[14:10] and `rn_idx` = insn[9:5], for every word, including undefined ones.
- R3: `undef` is 1 when any of these holds: `fp_present` is 0, opc (insn[31:30]) is 11, insn[29:27] is not 101, insn[26] is not 1, insn[22] is not 0, or insn[25:23] is not one of 001, 011 or 010. When `undef` is 1, the enables, the fault, the tag flag, the address, the byte count, the data, the writeback value, `addr_mode` and `base_is_sp` are all 0.
- R4: insn[25:23] selects the addressing mode, reported on `addr_mode`. Class 001 is post-index (mode 2), class 011 is pre-index (mode 1) and class 010 is signed offset (mode 0). Only post-index and pre-index request writeback.
- R5: `acc_bytes` is 8, 16 or 32 for opc 00, 01 or 10.
- R6: The byte offset is imm7 (insn[21:15]) sign-extended and multiplied by 4, 8 or 16 for opc 00, 01 or 10. `acc_addr` is base + offset in pre-index and signed-offset modes, and the unmodified base in post-index mode.
- R7: `wb_value` is base + offset in every legal mode. `wb_en` is 1 for legal pre-index and post-index words unless a stack-pointer alignment fault is raised.
- R8: When rn is 31, the base is `sp_val` and `base_is_sp` is 1. For any other rn, the base is `base_x`.
- R9: Each element is the low 32, 64 or 128 bits of a register, chosen by opc. `store_data` is {rt element, rt2 element} when `big_endian` is 1 and {rt2 element, rt element} when it is 0. The result is zero-extended to 256 bits.
- R10: `sp_align_fault` is 1 for a legal word with rn = 31 and `sp_val[3:0]` nonzero. A fault forces `store_en` and `wb_en` to 0. Otherwise `store_en` is 1 for every legal word.
- R11: `tag_check` is 1 for a legal word when writeback is requested or rn is not 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs hold a request this cycle |
| insn | input | 32 | Instruction word |
| base_x | input | 64 | General register value for the base |
| sp_val | input | 64 | Stack pointer value |
| vreg_a | input | 128 | Read value of the rt register |
| vreg_b | input | 128 | Read value of the rt2 register |
| big_endian | input | 1 | Big-endian data order |
| fp_present | input | 1 | Floating-point support present |
| out_valid | output | 1 | Results valid |
| rt_idx | output | 5 | First data register index |
| rt2_idx | output | 5 | Second data register index |
| rn_idx | output | 5 | Base register index |
| addr_mode | output | 2 | 0 signed offset, 1 pre-index, 2 post-index |
| acc_addr | output | 64 | Access address |
| acc_bytes | output | 6 | Total access size in bytes |
| store_data | output | 256 | Ordered pair data |
| store_en | output | 1 | Store may be issued |
| wb_en | output | 1 | Write `wb_value` back to the base |
| wb_value | output | 64 | Updated base value |
| base_is_sp | output | 1 | Base is the stack pointer |
| undef | output | 1 | Undefined instruction |
| sp_align_fault | output | 1 | Stack pointer misaligned |
| tag_check | output | 1 | Access is tag-checked |

## Verification
The unit holds no state between requests apart from the result register, so a wrong decode, a wrong base choice or a wrong offset scale shows up on the very next `out_valid` cycle as a wrong address, writeback value or data order. Mode and endianness mix-ups show mainly in how `acc_addr` relates to `wb_value` and in which half of `store_data` holds the rt element. Random words are mixed with directed ones that cover the imm7 extremes, a misaligned stack pointer, opc 11 and missing floating-point support.

// File: rtl/pstq_pkg.sv
package pstq_pkg;
    typedef enum logic [1:0] {
        AM_OFFSET = 2'd0,
        AM_PRE    = 2'd1,
        AM_POST   = 2'd2
    } amode_t;

    localparam logic [2:0] CLS_POST   = 3'b001;
    localparam logic [2:0] CLS_PRE    = 3'b011;
    localparam logic [2:0] CLS_OFFSET = 3'b010;
    localparam logic [2:0] FIXED_PAT  = 3'b101;
    localparam logic [4:0] SP_INDEX   = 5'd31;
endpackage

// File: rtl/pstq_decode.sv
module pstq_decode
    import pstq_pkg::*;
(
    input  logic [31:0] insn,
    input  logic        fp_present,
    output logic [4:0]  rt,
    output logic [4:0]  rt2,
    output logic [4:0]  rn,
    output logic [1:0]  opc,
    output logic [6:0]  imm7,
    output amode_t      mode,
    output logic        wback,
    output logic        legal
);
    logic [2:0] cls;
    logic       cls_ok;

    always_comb begin
        rt   = insn[4:0];
        rn   = insn[9:5];
        rt2  = insn[14:10];
        imm7 = insn[21:15];
        opc  = insn[31:30];
        cls  = insn[25:23];
        unique case (cls)
            CLS_POST: begin mode = AM_POST;   cls_ok = 1'b1; end
            CLS_PRE:  begin mode = AM_PRE;    cls_ok = 1'b1; end
            CLS_OFFSET: begin mode = AM_OFFSET; cls_ok = 1'b1; end
            default:  begin mode = AM_OFFSET; cls_ok = 1'b0; end
        endcase
        legal = fp_present && (opc != 2'b11) && (insn[29:27] == FIXED_PAT)
              && insn[26] && !insn[22] && cls_ok;
        wback = legal && (mode != AM_OFFSET);
    end
endmodule

// File: rtl/pstq_addr.sv
module pstq_addr
    import pstq_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic [6:0]    imm7,
    input  logic [1:0]    opc,
    input  amode_t        mode,
    input  logic [4:0]    rn,
    input  logic [AW-1:0] base_x,
    input  logic [AW-1:0] sp_val,
    output logic [AW-1:0] acc_addr,
    output logic [AW-1:0] wb_value,
    output logic          base_is_sp,
    output logic          sp_misaligned
);
    logic [2:0]    scale;
    logic [AW-1:0] sext;
    logic [AW-1:0] offset;
    logic [AW-1:0] base;
    logic [AW-1:0] moved;

    always_comb begin
        scale         = 3'd2 + {1'b0, opc};
        sext          = {{(AW-7){imm7[6]}}, imm7};
        offset        = sext << scale;
        base_is_sp    = (rn == SP_INDEX);
        base          = base_is_sp ? sp_val : base_x;
        moved         = base + offset;
        acc_addr      = (mode == AM_POST) ? base : moved;
        wb_value      = moved;
        sp_misaligned = base_is_sp && (sp_val[3:0] != 4'd0);
    end
endmodule

// File: rtl/pstq_pack.sv
module pstq_pack #(
    parameter int EW = 128
) (
    input  logic [EW-1:0]   vreg_a,
    input  logic [EW-1:0]   vreg_b,
    input  logic [1:0]      opc,
    input  logic            big_endian,
    output logic [2*EW-1:0] data
);
    localparam int NSIZE = 3;

    logic [NSIZE-1:0][2*EW-1:0] cand;

    for (genvar g = 0; g < NSIZE; g++) begin : g_size
        localparam int W = 32 << g;
        logic [2*W-1:0] pair;
        always_comb begin
            pair    = big_endian ? {vreg_a[W-1:0], vreg_b[W-1:0]}
                                 : {vreg_b[W-1:0], vreg_a[W-1:0]};
            cand[g] = (2*EW)'(pair);
        end
    end

    always_comb begin
        data = (opc < 2'(NSIZE)) ? cand[opc] : '0;
    end
endmodule

// File: rtl/pair_store_agu.sv
module pair_store_agu
    import pstq_pkg::*;
#(
    parameter int AW = 64,
    parameter int EW = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [AW-1:0]   base_x,
    input  logic [AW-1:0]   sp_val,
    input  logic [EW-1:0]   vreg_a,
    input  logic [EW-1:0]   vreg_b,
    input  logic            big_endian,
    input  logic            fp_present,
    output logic            out_valid,
    output logic [4:0]      rt_idx,
    output logic [4:0]      rt2_idx,
    output logic [4:0]      rn_idx,
    output logic [1:0]      addr_mode,
    output logic [AW-1:0]   acc_addr,
    output logic [$clog2(EW/4):0] acc_bytes,
    output logic [2*EW-1:0] store_data,
    output logic            store_en,
    output logic            wb_en,
    output logic [AW-1:0]   wb_value,
    output logic            base_is_sp,
    output logic            undef,
    output logic            sp_align_fault,
    output logic            tag_check
);
    localparam int BW = $clog2(EW/4) + 1;

    typedef struct packed {
        logic [4:0]      rt;
        logic [4:0]      rt2;
        logic [4:0]      rn;
        logic [1:0]      mode;
        logic [AW-1:0]   addr;
        logic [BW-1:0]   bytes;
        logic [2*EW-1:0] data;
        logic            st;
        logic            wb;
        logic [AW-1:0]   wbv;
        logic            bsp;
        logic            undef;
        logic            fault;
        logic            tag;
    } res_t;

    logic [4:0]      dec_rt, dec_rt2, dec_rn;
    logic [1:0]      dec_opc;
    logic [6:0]      dec_imm;
    amode_t          dec_mode;
    logic            dec_wback, dec_legal;
    logic [AW-1:0]   a_addr, a_wbv;
    logic            a_bsp, a_mis;
    logic [2*EW-1:0] p_data;

    res_t res_d, res_q;
    logic valid_d, valid_q;

    pstq_decode u_dec (
        .insn(insn), .fp_present(fp_present),
        .rt(dec_rt), .rt2(dec_rt2), .rn(dec_rn), .opc(dec_opc), .imm7(dec_imm),
        .mode(dec_mode), .wback(dec_wback), .legal(dec_legal)
    );

    pstq_addr #(.AW(AW)) u_addr (
        .imm7(dec_imm), .opc(dec_opc), .mode(dec_mode), .rn(dec_rn),
        .base_x(base_x), .sp_val(sp_val),
        .acc_addr(a_addr), .wb_value(a_wbv), .base_is_sp(a_bsp), .sp_misaligned(a_mis)
    );

    pstq_pack #(.EW(EW)) u_pack (
        .vreg_a(vreg_a), .vreg_b(vreg_b), .opc(dec_opc), .big_endian(big_endian),
        .data(p_data)
    );

    always_comb begin
        res_t nxt;
        logic flt;
        flt        = dec_legal && a_mis;
        nxt        = '0;
        nxt.rt     = dec_rt;
        nxt.rt2    = dec_rt2;
        nxt.rn     = dec_rn;
        nxt.undef  = !dec_legal;
        if (dec_legal) begin
            nxt.mode  = dec_mode;
            nxt.addr  = a_addr;
            nxt.bytes = BW'(8) << dec_opc;
            nxt.data  = p_data;
            nxt.wbv   = a_wbv;
            nxt.bsp   = a_bsp;
            nxt.fault = flt;
            nxt.st    = !flt;
            nxt.wb    = dec_wback && !flt;
            nxt.tag   = dec_wback || !a_bsp;
        end
        res_d   = in_valid ? nxt : res_q;
        valid_d = in_valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            res_q   <= res_d;
            valid_q <= valid_d;
        end
    end

    assign out_valid      = valid_q;
    assign rt_idx         = res_q.rt;
    assign rt2_idx        = res_q.rt2;
    assign rn_idx         = res_q.rn;
    assign addr_mode      = res_q.mode;
    assign acc_addr       = res_q.addr;
    assign acc_bytes      = res_q.bytes;
    assign store_data     = res_q.data;
    assign store_en       = res_q.st;
    assign wb_en          = res_q.wb;
    assign wb_value       = res_q.wbv;
    assign base_is_sp     = res_q.bsp;
    assign undef          = res_q.undef;
    assign sp_align_fault = res_q.fault;
    assign tag_check      = res_q.tag;
endmodule

// File: rtl/pstq_chk.sv
module pstq_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [31:0]   insn,
    input logic [AW-1:0] base_x,
    input logic [AW-1:0] sp_val,
    input logic          out_valid,
    input logic [1:0]    addr_mode,
    input logic [AW-1:0] acc_addr,
    input logic [4:0]    rn_idx,
    input logic          store_en,
    input logic          wb_en,
    input logic          undef,
    input logic          sp_align_fault,
    input logic          tag_check
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    p_rn_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> rn_idx == $past(insn[9:5]));
    p_undef_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> !store_en && !wb_en && !sp_align_fault && !tag_check);
    p_offset_no_wb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !undef && addr_mode == 2'd0) |-> !wb_en);
    p_post_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !undef && addr_mode == 2'd2)
        |-> acc_addr == (($past(insn[9:5]) == 5'd31) ? $past(sp_val) : $past(base_x)));
    p_fault_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sp_align_fault |-> !store_en && !wb_en);
    p_tag_non_sp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !undef && rn_idx != 5'd31) |-> tag_check);
endmodule

bind pair_store_agu pstq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .base_x(base_x), .sp_val(sp_val), .out_valid(out_valid),
    .addr_mode(addr_mode), .acc_addr(acc_addr), .rn_idx(rn_idx),
    .store_en(store_en), .wb_en(wb_en), .undef(undef),
    .sp_align_fault(sp_align_fault), .tag_check(tag_check)
);

// File: tb/pair_store_agu_tb.sv
module pair_store_agu_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [63:0]  base_x = '0, sp_val = '0;
    logic [127:0] vreg_a = '0, vreg_b = '0;
    logic         big_endian = 1'b0, fp_present = 1'b1;
    logic         out_valid, store_en, wb_en, base_is_sp, undef, sp_align_fault, tag_check;
    logic [4:0]   rt_idx, rt2_idx, rn_idx;
    logic [1:0]   addr_mode;
    logic [63:0]  acc_addr, wb_value;
    logic [5:0]   acc_bytes;
    logic [255:0] store_data;

    int n_run = 0;
    int n_fail = 0;

    pair_store_agu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .base_x(base_x), .sp_val(sp_val), .vreg_a(vreg_a), .vreg_b(vreg_b),
        .big_endian(big_endian), .fp_present(fp_present),
        .out_valid(out_valid), .rt_idx(rt_idx), .rt2_idx(rt2_idx), .rn_idx(rn_idx),
        .addr_mode(addr_mode), .acc_addr(acc_addr), .acc_bytes(acc_bytes),
        .store_data(store_data), .store_en(store_en), .wb_en(wb_en),
        .wb_value(wb_value), .base_is_sp(base_is_sp), .undef(undef),
        .sp_align_fault(sp_align_fault), .tag_check(tag_check)
    );

    task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] opc, input logic [2:0] cls,
                                       input logic [6:0] imm, input logic [4:0] rt2,
                                       input logic [4:0] rn, input logic [4:0] rt);
        return {opc, 3'b101, 1'b1, cls, 1'b0, imm, rt2, rn, rt};
    endfunction

    task automatic run(input logic [31:0] w, input logic [63:0] bx, input logic [63:0] sp,
                       input logic [127:0] a, input logic [127:0] b, input bit be, input bit fp);
        logic [1:0]   opc;
        logic [2:0]   cls;
        logic [4:0]   rn;
        bit           legal, wbk, flt;
        logic [1:0]   md;
        logic [63:0]  base, off, e_addr, e_wbv;
        logic [5:0]   e_bytes;
        logic [255:0] e_data;
        int           esz;
        opc = w[31:30]; cls = w[25:23]; rn = w[9:5];
        legal = fp && opc != 2'b11 && w[29:27] == 3'b101 && w[26] && !w[22]
                && (cls == 3'b001 || cls == 3'b011 || cls == 3'b010);
        md = !legal ? 2'd0 : (cls == 3'b001) ? 2'd2 : (cls == 3'b011) ? 2'd1 : 2'd0;
        wbk = legal && cls != 3'b010;
        base = (rn == 5'd31) ? sp : bx;
        off = 64'(longint'($signed(w[21:15])) * (longint'(4) << opc));
        e_addr = !legal ? 64'd0 : (md == 2'd2) ? base : base + off;
        e_wbv = legal ? base + off : 64'd0;
        e_bytes = legal ? 6'(8 << opc) : 6'd0;
        esz = 32 << opc;
        e_data = '0;
        if (legal) begin
            for (int i = 0; i < 128; i++) begin
                if (i < esz) begin
                    e_data[i]       = be ? b[i] : a[i];
                    e_data[i + esz] = be ? a[i] : b[i];
                end
            end
        end
        flt = legal && rn == 5'd31 && sp[3:0] != 4'd0;

        @(negedge clk);
        insn = w; base_x = bx; sp_val = sp; vreg_a = a; vreg_b = b;
        big_endian = be; fp_present = fp; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R1 out_valid", 256'(out_valid), 256'(1));
        chk(rt_idx == w[4:0] && rt2_idx == w[14:10] && rn_idx == rn, "R2 indices",
            256'({rt_idx, rt2_idx, rn_idx}), 256'({w[4:0], w[14:10], rn}));
        chk(undef == !legal, "R3 undef", 256'(undef), 256'(!legal));
        chk(addr_mode == md, "R4 addr_mode", 256'(addr_mode), 256'(md));
        chk(acc_bytes == e_bytes, "R5 acc_bytes", 256'(acc_bytes), 256'(e_bytes));
        chk(acc_addr == e_addr, "R6 acc_addr", 256'(acc_addr), 256'(e_addr));
        chk(wb_value == e_wbv && wb_en == (wbk && !flt), "R7 writeback",
            256'({wb_en, wb_value}), 256'({wbk && !flt, e_wbv}));
        chk(base_is_sp == (legal && rn == 5'd31), "R8 base_is_sp",
            256'(base_is_sp), 256'(legal && rn == 5'd31));
        chk(store_data == e_data, "R9 store_data", store_data, e_data);
        chk(sp_align_fault == flt && store_en == (legal && !flt), "R10 fault/store_en",
            256'({sp_align_fault, store_en}), 256'({flt, legal && !flt}));
        chk(tag_check == (legal && (wbk || rn != 5'd31)), "R11 tag_check",
            256'(tag_check), 256'(legal && (wbk || rn != 5'd31)));
    endtask

    function automatic logic [127:0] r128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && acc_addr == 0 && store_en == 0 && wb_en == 0 && undef == 0,
            "R1 reset state", 256'({out_valid, store_en, wb_en, undef}), 256'(0));

        // directed corners
        run(mk(2'b00, 3'b001, 7'h40, 5'd3, 5'd4, 5'd5), 64'h1000, 64'h8000,
            128'h11, 128'h22, 1'b0, 1'b1);                         // R6 most negative
        run(mk(2'b10, 3'b011, 7'h3f, 5'd7, 5'd31, 5'd8), 64'h0, 64'hfff0,
            r128(), r128(), 1'b1, 1'b1);                           // R8 sp base, max positive
        run(mk(2'b01, 3'b010, 7'h7f, 5'd1, 5'd31, 5'd2), 64'h0, 64'h4008,
            r128(), r128(), 1'b0, 1'b1);                           // R10 misaligned sp
        run(mk(2'b01, 3'b010, 7'h05, 5'd1, 5'd31, 5'd2), 64'h0, 64'h4000,
            r128(), r128(), 1'b1, 1'b1);                           // R11 sp, no writeback
        run(mk(2'b11, 3'b001, 7'h01, 5'd1, 5'd2, 5'd3), 64'h10, 64'h0,
            r128(), r128(), 1'b0, 1'b1);                           // R3 opc 11
        run(mk(2'b00, 3'b011, 7'h01, 5'd1, 5'd2, 5'd3), 64'h10, 64'h0,
            r128(), r128(), 1'b0, 1'b0);                           // R3 no fp
        run(mk(2'b00, 3'b000, 7'h01, 5'd1, 5'd2, 5'd3), 64'h10, 64'h0,
            r128(), r128(), 1'b0, 1'b1);                           // R3 bad class
        run(mk(2'b00, 3'b011, 7'h01, 5'd1, 5'd2, 5'd3) | 32'h0040_0000, 64'h10, 64'h0,
            r128(), r128(), 1'b0, 1'b1);                           // R3 load bit set

        // R1: no request means out_valid drops
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle", 256'(out_valid), 256'(0));

        for (int k = 0; k < 400; k++) begin
            logic [31:0] w;
            logic [2:0]  cls;
            logic [4:0]  rn;
            logic [63:0] sp;
            int          pick;
            pick = $urandom_range(0, 2);
            cls = (pick == 0) ? 3'b001 : (pick == 1) ? 3'b011 : 3'b010;
            rn = ($urandom_range(0, 3) == 0) ? 5'd31 : 5'($urandom());
            w = mk(2'($urandom_range(0, 2)), cls, 7'($urandom()), 5'($urandom()), rn, 5'($urandom()));
            if ($urandom_range(0, 9) == 0) w = w ^ (32'd1 << $urandom_range(22, 31));
            if ($urandom_range(0, 19) == 0) w = $urandom();
            sp = {$urandom(), $urandom()};
            if ($urandom_range(0, 4) != 0) sp[3:0] = 4'd0;
            run(w, {$urandom(), $urandom()}, sp, r128(), r128(),
                1'($urandom()), $urandom_range(0, 15) != 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule